// File: doc/BRIEF.md
# Reset and Power-Mode Controller

This block sits next to a small 8-bit controller core and owns its clock enables, its internal reset and its low-power state. It divides the oscillator into a two-phase clock. It counts oscillator periods into twelve-period machine cycles. It turns a noisy, asynchronous reset pin into a clean internal reset that appears only after the pin has been held through two full machine cycles of running oscillator.

Software selects a low-power state by writing two request bits: a light sleep bit and a deep sleep bit. The chosen state takes hold when the writing instruction ends. In light sleep (idle) the CPU clock enable drops and the peripheral clock enable stays high. Any enabled interrupt ends idle, and so does a qualified reset. In deep sleep (power-down) the oscillator is stopped and only a reset can end it. The reset pin is watched without a clock so that it can restart the oscillator, and the two-machine-cycle qualification then runs on the restarted clock.

The `rst_n` input is a synchronous active-low initialisation for the controller's own flops. It is separate from the qualified reset pin.

Top module: `pwr_rst_ctrl`

## Requirements
- R1: Whenever the oscillator is running, `phase` toggles on every clock edge. It is 0 after `rst_n`.
- R2: `mc_tick` is high for exactly one period out of every 12 running oscillator periods, so consecutive ticks are 12 cycles apart.
- R3: `rst_pin` passes through a two-flop synchroniser and a 24-period qualification counter. If the pin goes high before clock edge 1, `sys_rst` is first seen high after edge 26. It then stays high for as long as the pin stays high.
- R4: If the pin is released before the count completes, the counter restarts and `sys_rst` never asserts. A high stretch of 23 edges or fewer gives no reset; 24 or more gives one.
- R5: In idle, `cpu_clk_en`=0, `periph_clk_en`=1 and `osc_run`=1, and `idle_flag`=1.
- R6: In idle, `irq_wake` returns the block to run on the next edge (`cpu_clk_en`=1) and clears `idle_flag`. In run, `irq_wake` has no effect.
- R7: In power-down with the pin low, `osc_run`, `cpu_clk_en` and `periph_clk_en` are 0, `phase` is frozen and no `mc_tick` occurs. `irq_wake` is ignored.
- R8: In power-down, a high `rst_pin` raises `osc_run` in the same cycle, with no clock edge needed. Power-down is left only when the qualified reset completes. An early release drops `osc_run` again and keeps `pd_flag`=1.
- R9: An asserted `sys_rst` clears both request flags and returns the block to run.
- R10: If both request bits are set when the instruction ends, the block enters power-down (`osc_run`=0).
- R11: `ctl_wr` loads `idle_flag`/`pd_flag` from `ctl_idle`/`ctl_pd` on the next edge, and only in run. A mode is entered on an `instr_end` pulse that sees a flag already set. `instr_end` with both flags clear leaves the block in run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator input |
| rst_n | input | 1 | Synchronous active-low initialisation of this block |
| rst_pin | input | 1 | Asynchronous active-high reset pin |
| ctl_wr | input | 1 | Write strobe for the request bits |
| ctl_idle | input | 1 | Idle request value written by `ctl_wr` |
| ctl_pd | input | 1 | Power-down request value written by `ctl_wr` |
| instr_end | input | 1 | Pulse marking the end of the current instruction |
| irq_wake | input | 1 | An enabled interrupt is pending |
| sys_rst | output | 1 | Qualified internal reset, active high |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| osc_run | output | 1 | Oscillator running |
| phase | output | 1 | Divide-by-two clock phase |
| mc_tick | output | 1 | Last oscillator period of a machine cycle |
| idle_flag | output | 1 | Idle request bit |
| pd_flag | output | 1 | Power-down request bit |

## Verification
The hardest situation to reach from the ports is waking from power-down. The counter that must qualify the reset is clocked only through the pin itself, and a release one cycle early must leave the block asleep. The bench first puts the block into power-down through the request bit and an instruction end. It then holds the pin for a short stretch and checks that the oscillator stops again. After that it holds the pin long enough to qualify. A sweep of pin-high lengths from 1 to 30 edges pins down the exact edge on which reset first appears, and the 23/24 boundary.

// File: rtl/pmc_pkg.sv
// Shared types for the reset and power-mode controller.
package pmc_pkg;
    typedef enum logic [1:0] {
        MODE_RUN   = 2'd0,
        MODE_IDLE  = 2'd1,
        MODE_PDOWN = 2'd2
    } pmc_mode_e;
endpackage

// File: rtl/pmc_pin_sync.sv
// Multi-flop synchroniser for the asynchronous reset pin.
// Assumes STAGES >= 2; output follows the pin STAGES edges later.
module pmc_pin_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_async,
    output logic pin_sync
);
    logic [STAGES-1:0] chain_q;

    // Shift the raw pin through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain_q <= '0;
        else        chain_q <= {chain_q[STAGES-2:0], pin_async};
    end

    assign pin_sync = chain_q[STAGES-1];

    p_sync_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        chain_q[STAGES-2] |=> pin_sync);
endmodule

// File: rtl/pmc_clk_div.sv
// Divide-by-two phase and machine-cycle counter.
// Both freeze while osc_en is low, which models a stopped oscillator.
module pmc_clk_div #(
    parameter int OSC_PER_MC = 12
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    output logic phase,
    output logic mc_tick
);
    localparam int CW = $clog2(OSC_PER_MC);
    localparam logic [CW-1:0] LAST = CW'(OSC_PER_MC - 1);

    logic [CW-1:0] mc_cnt;
    logic          at_last;

    assign at_last = (mc_cnt == LAST);

    // Toggle the phase flop on every running oscillator period.
    always_ff @(posedge clk) begin
        if (!rst_n)      phase <= 1'b0;
        else if (osc_en) phase <= ~phase;
    end

    // Count oscillator periods within a machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)       mc_cnt <= '0;
        else if (osc_en)  mc_cnt <= at_last ? '0 : mc_cnt + 1'b1;
    end

    assign mc_tick = at_last & osc_en;

    p_phase_toggle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        osc_en |=> (phase != $past(phase)));
    p_tick_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mc_tick |=> (mc_cnt == '0));
    p_freeze_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !osc_en |=> ($stable(phase) && $stable(mc_cnt)));
endmodule

// File: rtl/pmc_rst_qual.sv
// Qualifies the synchronised reset pin: internal reset only after the pin
// has been seen high for RST_COUNT running oscillator periods.
module pmc_rst_qual #(
    parameter int RST_COUNT = 24
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_en,
    input  logic pin_sync,
    output logic sys_rst
);
    localparam int CW = $clog2(RST_COUNT + 1);
    localparam logic [CW-1:0] FULL = CW'(RST_COUNT);

    logic [CW-1:0] hold_cnt;

    // Count held periods; restart when the pin drops; saturate at full.
    always_ff @(posedge clk) begin
        if (!rst_n)                           hold_cnt <= '0;
        else if (!pin_sync)                   hold_cnt <= '0;
        else if (osc_en && hold_cnt != FULL)  hold_cnt <= hold_cnt + 1'b1;
    end

    assign sys_rst = (hold_cnt == FULL);

    p_rst_needs_pin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_rst) |-> $past(pin_sync));
    p_release_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !pin_sync |=> (hold_cnt == '0));
endmodule

// File: rtl/pmc_mode_fsm.sv
// Run / idle / power-down state and the two request bits.
// Assumes instr_end pulses once at the end of every CPU instruction.
module pmc_mode_fsm
    import pmc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sys_rst,
    input  logic      ctl_wr,
    input  logic      ctl_idle,
    input  logic      ctl_pd,
    input  logic      instr_end,
    input  logic      irq_wake,
    output pmc_mode_e mode,
    output logic      idle_bit,
    output logic      pd_bit
);
    // Mode transitions and request-bit updates.
    always_ff @(posedge clk) begin
        if (!rst_n || sys_rst) begin
            mode     <= MODE_RUN;
            idle_bit <= 1'b0;
            pd_bit   <= 1'b0;
        end else begin
            case (mode)
                MODE_RUN: begin
                    if (instr_end && pd_bit)        mode <= MODE_PDOWN;
                    else if (instr_end && idle_bit) mode <= MODE_IDLE;
                    if (ctl_wr) begin
                        idle_bit <= ctl_idle;
                        pd_bit   <= ctl_pd;
                    end
                end
                MODE_IDLE: begin
                    if (irq_wake) begin
                        mode     <= MODE_RUN;
                        idle_bit <= 1'b0;
                    end
                end
                MODE_PDOWN: mode <= MODE_PDOWN;
                default:    mode <= MODE_RUN;
            endcase
        end
    end

    p_pd_only_rst_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_PDOWN && !sys_rst) |=> (mode == MODE_PDOWN));
    p_idle_wake_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDLE && irq_wake && !sys_rst) |=> (mode == MODE_RUN && !idle_bit));
    p_rst_clears_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |=> (mode == MODE_RUN && !idle_bit && !pd_bit));
    p_pd_priority_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_RUN && instr_end && pd_bit && !sys_rst) |=> (mode == MODE_PDOWN));
endmodule

// File: rtl/pwr_rst_ctrl.sv
// Reset and power-mode controller top.
// Derives the oscillator gate from the mode and the raw reset pin, and
// drives the CPU and peripheral clock enables from the mode.
module pwr_rst_ctrl
    import pmc_pkg::*;
#(
    parameter int OSC_PER_MC  = 12,
    parameter int RST_MCYC    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rst_pin,
    input  logic ctl_wr,
    input  logic ctl_idle,
    input  logic ctl_pd,
    input  logic instr_end,
    input  logic irq_wake,
    output logic sys_rst,
    output logic cpu_clk_en,
    output logic periph_clk_en,
    output logic osc_run,
    output logic phase,
    output logic mc_tick,
    output logic idle_flag,
    output logic pd_flag
);
    localparam int RST_COUNT = OSC_PER_MC * RST_MCYC;

    pmc_mode_e mode;
    logic      pin_sync;
    logic      osc_en;

    // Oscillator runs unless powered down; the raw pin restarts it.
    assign osc_en = (mode != MODE_PDOWN) | rst_pin;

    pmc_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .pin_async(rst_pin), .pin_sync(pin_sync));

    pmc_rst_qual #(.RST_COUNT(RST_COUNT)) u_qual (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en),
        .pin_sync(pin_sync), .sys_rst(sys_rst));

    pmc_clk_div #(.OSC_PER_MC(OSC_PER_MC)) u_div (
        .clk(clk), .rst_n(rst_n), .osc_en(osc_en),
        .phase(phase), .mc_tick(mc_tick));

    pmc_mode_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sys_rst(sys_rst),
        .ctl_wr(ctl_wr), .ctl_idle(ctl_idle), .ctl_pd(ctl_pd),
        .instr_end(instr_end), .irq_wake(irq_wake),
        .mode(mode), .idle_bit(idle_flag), .pd_bit(pd_flag));

    assign osc_run       = osc_en;
    assign cpu_clk_en    = osc_en & (mode == MODE_RUN);
    assign periph_clk_en = osc_en & (mode != MODE_PDOWN);

    p_cpu_needs_periph_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> periph_clk_en);
    p_pd_osc_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_flag && !cpu_clk_en && !idle_flag && !rst_pin) |-> !osc_run);
endmodule

// File: tb/tb_pwr_rst_ctrl.sv
module tb_pwr_rst_ctrl;
    logic clk = 1'b0;
    logic rst_n, rst_pin, ctl_wr, ctl_idle, ctl_pd, instr_end, irq_wake;
    logic sys_rst, cpu_clk_en, periph_clk_en, osc_run, phase, mc_tick, idle_flag, pd_flag;
    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    pwr_rst_ctrl dut (
        .clk(clk), .rst_n(rst_n), .rst_pin(rst_pin), .ctl_wr(ctl_wr),
        .ctl_idle(ctl_idle), .ctl_pd(ctl_pd), .instr_end(instr_end),
        .irq_wake(irq_wake), .sys_rst(sys_rst), .cpu_clk_en(cpu_clk_en),
        .periph_clk_en(periph_clk_en), .osc_run(osc_run), .phase(phase),
        .mc_tick(mc_tick), .idle_flag(idle_flag), .pd_flag(pd_flag));

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // One-cycle write of the request bits.
    task automatic write_bits(input logic i, input logic p);
        ctl_wr = 1'b1; ctl_idle = i; ctl_pd = p;
        cyc(1);
        ctl_wr = 1'b0; ctl_idle = 1'b0; ctl_pd = 1'b0;
    endtask

    task automatic end_instr();
        instr_end = 1'b1; cyc(1); instr_end = 1'b0;
    endtask

    task automatic pulse_irq();
        irq_wake = 1'b1; cyc(1); irq_wake = 1'b0;
    endtask

    // Hold the pin for len edges; return the first edge index with sys_rst high (0 = none).
    task automatic hold_pin(input int len, output int first);
        first = 0;
        rst_pin = 1'b1;
        for (int j = 1; j <= len + 8; j++) begin
            cyc(1);
            if (sys_rst && first == 0) first = j;
            if (j == len) rst_pin = 1'b0;
        end
        cyc(4);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired: actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int first, p0, last_tick, ticks;
        rst_n = 1'b0; rst_pin = 0; ctl_wr = 0; ctl_idle = 0; ctl_pd = 0;
        instr_end = 0; irq_wake = 0;
        cyc(3);
        rst_n = 1'b1;
        // Reset state
        check("R1 phase after rst_n", int'(phase), 0);
        check("R9 sys_rst after rst_n", int'(sys_rst), 0);
        check("R5 cpu_clk_en after rst_n", int'(cpu_clk_en), 1);
        check("R5 periph_clk_en after rst_n", int'(periph_clk_en), 1);
        check("R7 osc_run after rst_n", int'(osc_run), 1);
        check("R11 flags after rst_n", int'({idle_flag, pd_flag}), 0);

        // R1 / R2: phase alternation and tick spacing
        p0 = int'(phase); last_tick = -1; ticks = 0;
        for (int i = 0; i < 60; i++) begin
            cyc(1);
            check("R1 phase toggles", int'(phase), p0 ^ ((i + 1) % 2));
            if (mc_tick) begin
                if (last_tick >= 0) check("R2 tick spacing", i - last_tick, 12);
                last_tick = i; ticks++;
            end
        end
        check("R2 tick count in 60", ticks, 5);

        // R6: irq in run does nothing; R11: instr_end with no bits set stays in run
        pulse_irq();
        end_instr();
        check("R11 run kept", int'(cpu_clk_en), 1);
        check("R6 irq in run", int'(idle_flag), 0);

        // R11: same-cycle write and instr_end does not enter
        ctl_wr = 1; ctl_idle = 1; instr_end = 1; cyc(1);
        ctl_wr = 0; ctl_idle = 0; instr_end = 0;
        check("R11 same-cycle no entry", int'(cpu_clk_en), 1);
        check("R11 idle flag loaded", int'(idle_flag), 1);
        // R5: enter idle on the next instruction end
        end_instr();
        check("R5 idle cpu off", int'(cpu_clk_en), 0);
        check("R5 idle periph on", int'(periph_clk_en), 1);
        check("R5 idle osc on", int'(osc_run), 1);
        // R11: writes ignored outside run
        write_bits(1'b0, 1'b1);
        check("R11 write ignored in idle", int'(pd_flag), 0);
        cyc(5);
        check("R5 idle holds", int'(cpu_clk_en), 0);
        // R6: wake on interrupt
        pulse_irq();
        check("R6 wake cpu on", int'(cpu_clk_en), 1);
        check("R6 idle flag cleared", int'(idle_flag), 0);

        // R7: power-down
        write_bits(1'b0, 1'b1);
        end_instr();
        check("R7 pd osc off", int'(osc_run), 0);
        check("R7 pd cpu off", int'(cpu_clk_en), 0);
        check("R7 pd periph off", int'(periph_clk_en), 0);
        p0 = int'(phase); ticks = 0;
        for (int i = 0; i < 20; i++) begin
            cyc(1);
            if (mc_tick) ticks++;
            check("R7 phase frozen", int'(phase), p0);
        end
        check("R7 no ticks", ticks, 0);
        pulse_irq();
        check("R7 irq ignored", int'(osc_run), 0);
        check("R7 pd flag kept", int'(pd_flag), 1);

        // R8: early release keeps power-down
        rst_pin = 1'b1; #1;
        check("R8 pin restarts osc", int'(osc_run), 1);
        cyc(10); rst_pin = 1'b0; #1;
        check("R8 osc stops on release", int'(osc_run), 0);
        cyc(5);
        check("R8 still pd", int'(pd_flag), 1);
        check("R8 no sys_rst", int'(sys_rst), 0);
        // R8 / R9: full qualification leaves power-down
        hold_pin(30, first);
        check("R8 qualified reset edge", first, 26);
        check("R9 pd cleared", int'(pd_flag), 0);
        check("R9 back to run", int'(cpu_clk_en), 1);

        // R10: both bits -> power-down; R9 clears both
        write_bits(1'b1, 1'b1);
        end_instr();
        check("R10 both -> pd", int'(osc_run), 0);
        check("R10 periph off", int'(periph_clk_en), 0);
        hold_pin(26, first);
        check("R9 both flags cleared", int'({idle_flag, pd_flag}), 0);
        check("R9 run after reset", int'(cpu_clk_en), 1);

        // R3 / R4: sweep of pin-high lengths
        for (int len = 1; len <= 30; len++) begin
            hold_pin(len, first);
            if (len >= 24) check("R3 reset edge", first, 26);
            else           check("R4 short pulse no reset", first, 0);
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule